// File: doc/BRIEF.md
# PCI Power Management Capability Block

This block holds the power management capability structure of one PCIe function. It occupies two configuration dwords. The lower dword carries a fixed capability header and a read-only capabilities word. The upper dword carries the control/status halfword, a zero bridge-extension byte and a power-data byte. Configuration writes and reads arrive on a plain dword-addressed port with byte enables. Reads are combinational from the current register state.

A wake-event input latches a PME status flag. When the PME enable bit is also set, the block raises a PME request toward the message logic. Software moves the function between D0 and D3. The intermediate D1 and D2 codes are dropped. Leaving D3 for D0 emits a one-cycle pulse that asks the surrounding logic for an internal soft reset.

Power data is preloaded on an input vector, one byte per data index. A selector chooses which byte is shown and which scale accompanies it. Two reset kinds are modelled. The full power-up reset `rst_n` clears everything. The D3cold-exit event `cold_exit_i` keeps the PME flags when auxiliary power is present.

Top module: `pmcap_top`

## Requirements
- R1: The dword at index `CAP_DW` (default 0x10) reads 0x01 in bits 7:0 (capability ID). Bits 15:8 hold the next pointer: 0x50 for a normal function and 0xA0 when `IS_DUMMY` is 1.
- R2: Bits 31:16 of that dword read 0x4823 when `aux_pwr_i` is 0 and 0xC823 when it is 1. In those values the wake-support field (bits 31:27) is 01001b or 11001b, DSI (bit 21) is 1, the version (bits 18:16) is 011b, and every other bit is 0.
- R3: The power state field sits in bits 1:0 of dword `CAP_DW+1` and on `pwr_state_o`, with 00 = D0 and 11 = D3. A write of 00 or 11 through byte lane 0 takes effect. A write of 01 or 10 leaves the state unchanged.
- R4: A write that moves the state from 11 to 00 drives `soft_rst_o` high for exactly the one clock cycle after that write's clock edge. Writes that leave the state unchanged (00 to 00, 11 to 11) produce no pulse.
- R5: A cycle with `wake_evt_i` high sets PME status (bit 15) whatever the enable. Writing 1 to bit 15 clears it. When a wake and a clearing write fall in the same cycle, the status ends up set.
- R6: PME enable (bit 8) is read/write through byte lane 1. `pme_req_o` is high exactly while status and enable are both 1.
- R7: The data selector (bits 12:9) follows byte-lane-1 writes only while `pm_en_strap_i` is 1. While the strap is 0 it reads 0000b from the next cycle on.
- R8: For selector values 0, 3, 4, 7 and 8 (8 only when `FUNC_NUM` is 0), the scale (bits 14:13) reads 01b and bits 31:24 read byte `sel` of `pwr_data_i`. For all other values both read 0.
- R9: Bits 7:2 and bits 23:16 of the control dword read 0, including No_Soft_Reset at bit 3. Writes to the read-only bits and to the header dword change nothing.
- R10: `rst_n` low clears state, selector, enable, status and the pulse. `cold_exit_i` returns the state to D0 and the selector to 0 without a pulse. It clears enable and status only when `aux_pwr_i` is 0, and it discards any configuration write in that cycle.
- R11: Reads of any other dword index return 0. Writes there, or with the relevant byte enable low, leave every field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low full power-up reset |
| cold_exit_i | input | 1 | One-cycle D3cold-exit reset event |
| aux_pwr_i | input | 1 | Auxiliary power present |
| pm_en_strap_i | input | 1 | Power management enabled by configuration |
| wake_evt_i | input | 1 | Wake event detected |
| pwr_data_i | input | NUM_DATA*8 | Preloaded power-data bytes, byte k at bits 8k+7:8k |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration dword index |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` |
| pwr_state_o | output | 2 | Current power state |
| pme_req_o | output | 1 | PME request |
| soft_rst_o | output | 1 | One-cycle internal soft-reset request |

## Verification
PME status has two sources that can hit it in the same clock: the wake input setting it and a software write-1 clearing it. The bench raises `wake_evt_i` in the very cycle that carries a clearing write to bit 15. It then reads the status back as 1, and clears it again with a lone write to show that the clear path itself works. The D3cold exit is the other collision. A control write placed alongside it must be discarded, and the PME flags must survive only when aux power is present.

// File: rtl/pmcap_pkg.sv
// Shared constants, types and helpers for the power management capability.
// Assumes a 4-bit data selector and 8-bit power-data bytes.
package pmcap_pkg;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned DATA_W = 8;

    // Power state encodings as seen in the control field.
    typedef enum logic [1:0] {
        PST_D0 = 2'b00,
        PST_D1 = 2'b01,
        PST_D2 = 2'b10,
        PST_D3 = 2'b11
    } pst_e;

    // Software-visible control/status state.
    typedef struct packed {
        logic             pme_sts;
        logic             pme_en;
        logic [SEL_W-1:0] sel;
        pst_e             pst;
    } csr_s;

    localparam logic [7:0] CAP_ID_PM     = 8'h01;
    localparam logic [4:0] WAKE_NOAUX    = 5'b01001;
    localparam logic [4:0] WAKE_AUX      = 5'b11001;
    localparam logic [2:0] PM_VERSION    = 3'b011;
    localparam logic [1:0] SCALE_TENTH   = 2'b01;

    // Field positions inside the control halfword.
    localparam int unsigned POS_STS = 15;
    localparam int unsigned POS_EN  = 8;
    localparam int unsigned POS_SEL = 9;

    // True for selector values that carry a scaled power reading.
    function automatic logic sel_is_scaled(input logic [SEL_W-1:0] sel,
                                           input int unsigned fn);
        case (sel)
            4'd0, 4'd3, 4'd4, 4'd7: return 1'b1;
            4'd8:                   return (fn == 0);
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmcap_hdr.sv
// Builds the read-only header dword: capability ID, next pointer and the
// capabilities word. Assumes only the wake-support field varies at runtime,
// driven by the aux-power input.
module pmcap_hdr
    import pmcap_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h50
) (
    input  logic        aux_pwr_i,
    output logic [31:0] hdr_o
);

    logic [4:0]  wake_sup;
    logic [15:0] caps;

    // Wake-support field picks its value from aux power presence.
    always_comb begin
        wake_sup = aux_pwr_i ? WAKE_AUX : WAKE_NOAUX;
    end

    // Capabilities word: no D1/D2, no aux current, DSI set, no PME clock.
    always_comb begin
        caps = {wake_sup,     // 15:11 wake support
                1'b0,         // 10    D2 support
                1'b0,         // 9     D1 support
                3'b000,       // 8:6   aux current
                1'b1,         // 5     DSI
                1'b0,         // 4     reserved
                1'b0,         // 3     PME clock
                PM_VERSION};  // 2:0   version
    end

    // Full header dword.
    always_comb begin
        hdr_o = {caps, NEXT_PTR, CAP_ID_PM};
    end

endmodule

// File: rtl/pmcap_csr.sv
// Control/status state: power state, wake enable, wake status and data
// selector, plus the soft-reset pulse. Assumes the write strobe is already
// decoded to this dword, and that cold_exit_i is a one-cycle event.
module pmcap_csr
    import pmcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cold_exit_i,
    input  logic        aux_pwr_i,
    input  logic        pm_en_strap_i,
    input  logic        wake_evt_i,
    input  logic        wr_en_i,
    input  logic [1:0]  be_i,
    input  logic [15:0] wdata_i,
    output csr_s        csr_o,
    output logic        soft_rst_o
);

    pst_e             pst_q;
    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    logic             sts_q;
    logic             srst_q;

    logic             wr_ok;
    logic             wr_lo;
    logic             wr_hi;
    pst_e             req_pst;
    logic             req_legal;
    logic             leave_d3;
    logic             sts_clr;
    logic             drop_pme;
    logic             unused_bits;

    // Decode write lanes; a cold-exit cycle discards writes.
    always_comb begin
        wr_ok     = wr_en_i && !cold_exit_i;
        wr_lo     = wr_ok && be_i[0];
        wr_hi     = wr_ok && be_i[1];
        req_pst   = pst_e'(wdata_i[1:0]);
        req_legal = (req_pst == PST_D0) || (req_pst == PST_D3);
        leave_d3  = wr_lo && (pst_q == PST_D3) && (req_pst == PST_D0);
        sts_clr   = wr_hi && wdata_i[POS_STS];
        drop_pme  = cold_exit_i && !aux_pwr_i;
    end

    // Power state: only D0/D3 writes land; cold exit returns to D0.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_exit_i) begin
            pst_q <= PST_D0;
        end else if (wr_lo && req_legal) begin
            pst_q <= req_pst;
        end
    end

    // Soft-reset request: one cycle after the D3-to-D0 write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
        end else begin
            srst_q <= leave_d3;
        end
    end

    // Data selector: writable only with the strap set.
    always_ff @(posedge clk) begin
        if (!rst_n || cold_exit_i || !pm_en_strap_i) begin
            sel_q <= '0;
        end else if (wr_hi) begin
            sel_q <= wdata_i[POS_SEL +: SEL_W];
        end
    end

    // Wake enable: plain read/write, sticky over cold exit with aux power.
    always_ff @(posedge clk) begin
        if (!rst_n || drop_pme) begin
            en_q <= 1'b0;
        end else if (wr_hi) begin
            en_q <= wdata_i[POS_EN];
        end
    end

    // Wake status: set by wake (wins over clear), cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n || drop_pme) begin
            sts_q <= 1'b0;
        end else if (wake_evt_i) begin
            sts_q <= 1'b1;
        end else if (sts_clr) begin
            sts_q <= 1'b0;
        end
    end

    // Present the state as one struct.
    always_comb begin
        csr_o.pme_sts = sts_q;
        csr_o.pme_en  = en_q;
        csr_o.sel     = sel_q;
        csr_o.pst     = pst_q;
        soft_rst_o    = srst_q;
    end

    // Read-only bits of the write word are not used.
    assign unused_bits = &{1'b0, wdata_i[7:2], wdata_i[14:13]};

endmodule

// File: rtl/pmcap_pwrdata.sv
// Maps the data selector to a scale code and a power-data byte. Assumes the
// preloaded bytes are packed low index first; indices beyond NUM_DATA read 0.
module pmcap_pwrdata
    import pmcap_pkg::*;
#(
    parameter int unsigned FUNC_NUM = 0,
    parameter int unsigned NUM_DATA = 9
) (
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [NUM_DATA*DATA_W-1:0] data_i,
    output logic [1:0]                 scale_o,
    output logic [DATA_W-1:0]          data_o
);

    localparam int unsigned SPAN = 1 << SEL_W;

    logic [SPAN-1:0]   lane_vld;
    logic [DATA_W-1:0] lane_byte [SPAN];

    // One lane per selector value: valid flag and its byte.
    for (genvar g = 0; g < SPAN; g++) begin : g_lane
        if (g < NUM_DATA) begin : g_fed
            assign lane_byte[g] = data_i[g*DATA_W +: DATA_W];
        end else begin : g_empty
            assign lane_byte[g] = '0;
        end
        assign lane_vld[g] = sel_is_scaled(SEL_W'(g), FUNC_NUM);
    end

    // Selected scale and byte, zero for reserved selector values.
    always_comb begin
        scale_o = lane_vld[sel_i] ? SCALE_TENTH : 2'b00;
        data_o  = lane_vld[sel_i] ? lane_byte[sel_i] : '0;
    end

endmodule

// File: rtl/pmcap_top.sv
// Power management capability of one function: two config dwords starting
// at CAP_DW. Assumes reads are combinational and writes take one edge.
module pmcap_top
    import pmcap_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned CAP_DW   = 16,
    parameter int unsigned FUNC_NUM = 0,
    parameter bit          IS_DUMMY = 1'b0,
    parameter int unsigned NUM_DATA = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cold_exit_i,
    input  logic                       aux_pwr_i,
    input  logic                       pm_en_strap_i,
    input  logic                       wake_evt_i,
    input  logic [NUM_DATA*DATA_W-1:0] pwr_data_i,
    input  logic                       cfg_wr_i,
    input  logic [ADDR_W-1:0]          cfg_addr_i,
    input  logic [3:0]                 cfg_be_i,
    input  logic [31:0]                cfg_wdata_i,
    output logic [31:0]                cfg_rdata_o,
    output logic [1:0]                 pwr_state_o,
    output logic                       pme_req_o,
    output logic                       soft_rst_o
);

    localparam logic [ADDR_W-1:0] HDR_ADDR = ADDR_W'(CAP_DW);
    localparam logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(CAP_DW + 1);
    localparam logic [7:0]        NEXT_PTR = IS_DUMMY ? 8'hA0 : 8'h50;

    logic [31:0]       hdr_dw;
    csr_s              csr;
    logic [1:0]        scale;
    logic [DATA_W-1:0] pdata;
    logic              csr_wr;
    logic [15:0]       ctl_hw;
    logic              pme_sts_w;
    logic              pme_en_w;
    logic [SEL_W-1:0]  data_sel_w;
    logic              unused_in;

    pmcap_hdr #(
        .NEXT_PTR (NEXT_PTR)
    ) u_hdr (
        .aux_pwr_i (aux_pwr_i),
        .hdr_o     (hdr_dw)
    );

    // Write strobe for the control dword.
    always_comb begin
        csr_wr = cfg_wr_i && (cfg_addr_i == CSR_ADDR);
    end

    pmcap_csr u_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cold_exit_i   (cold_exit_i),
        .aux_pwr_i     (aux_pwr_i),
        .pm_en_strap_i (pm_en_strap_i),
        .wake_evt_i    (wake_evt_i),
        .wr_en_i       (csr_wr),
        .be_i          (cfg_be_i[1:0]),
        .wdata_i       (cfg_wdata_i[15:0]),
        .csr_o         (csr),
        .soft_rst_o    (soft_rst_o)
    );

    pmcap_pwrdata #(
        .FUNC_NUM (FUNC_NUM),
        .NUM_DATA (NUM_DATA)
    ) u_pwrdata (
        .sel_i   (csr.sel),
        .data_i  (pwr_data_i),
        .scale_o (scale),
        .data_o  (pdata)
    );

    // Control halfword with reserved bits and No_Soft_Reset at zero.
    always_comb begin
        ctl_hw = {csr.pme_sts, scale, csr.sel, csr.pme_en, 6'b000000, csr.pst};
    end

    // Read mux over the two capability dwords.
    always_comb begin
        if (cfg_addr_i == HDR_ADDR) begin
            cfg_rdata_o = hdr_dw;
        end else if (cfg_addr_i == CSR_ADDR) begin
            cfg_rdata_o = {pdata, 8'h00, ctl_hw};
        end else begin
            cfg_rdata_o = '0;
        end
    end

    // Function-level outputs.
    always_comb begin
        pwr_state_o = csr.pst;
        pme_req_o   = csr.pme_sts && csr.pme_en;
        pme_sts_w   = csr.pme_sts;
        pme_en_w    = csr.pme_en;
        data_sel_w  = csr.sel;
    end

    // Upper lanes hold only read-only bytes.
    assign unused_in = &{1'b0, cfg_be_i[3:2], cfg_wdata_i[31:16]};

endmodule

// File: rtl/pmcap_chk.sv
// Temporal checks on the power management capability, bound to pmcap_top.
// Assumes the internal status, enable and selector are brought to its ports.
module pmcap_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned CAP_DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cold_exit_i,
    input logic              aux_pwr_i,
    input logic              pm_en_strap_i,
    input logic              wake_evt_i,
    input logic              cfg_wr_i,
    input logic [ADDR_W-1:0] cfg_addr_i,
    input logic [1:0]        cfg_be_lo,
    input logic [1:0]        wr_pst,
    input logic [1:0]        pwr_state_o,
    input logic              pme_req_o,
    input logic              soft_rst_o,
    input logic              pme_sts,
    input logic              pme_en,
    input logic [3:0]        data_sel
);

    logic csr_wr;
    assign csr_wr = cfg_wr_i && (cfg_addr_i == ADDR_W'(CAP_DW + 1)) && !cold_exit_i;

    AST_STATE_ENCODED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o == 2'b00) || (pwr_state_o == 2'b11));  // R3
    AST_MID_STATE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && cfg_be_lo[0] && (wr_pst == 2'b01 || wr_pst == 2'b10)) |=> $stable(pwr_state_o));  // R3
    AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);  // R4
    AST_RST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (pwr_state_o == 2'b00) && ($past(pwr_state_o) == 2'b11));  // R4
    AST_WAKE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt_i && !cold_exit_i) |=> pme_sts);  // R5
    AST_REQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_req_o) |-> ($past(wake_evt_i) || $past(csr_wr && cfg_be_lo[1])));  // R6
    AST_SEL_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en_strap_i |=> (data_sel == 4'd0));  // R7
    AST_COLD_CLEARS_PME: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_exit_i && !aux_pwr_i) |=> (!pme_sts && !pme_en));  // R10
    AST_COLD_KEEPS_PME: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_exit_i && aux_pwr_i && !wake_evt_i) |=> ($stable(pme_sts) && $stable(pme_en)));  // R10
    AST_COLD_TO_D0: assert property (@(posedge clk) disable iff (!rst_n)
        cold_exit_i |=> ((pwr_state_o == 2'b00) && !soft_rst_o));  // R10

endmodule

bind pmcap_top pmcap_chk #(
    .ADDR_W (ADDR_W),
    .CAP_DW (CAP_DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cold_exit_i   (cold_exit_i),
    .aux_pwr_i     (aux_pwr_i),
    .pm_en_strap_i (pm_en_strap_i),
    .wake_evt_i    (wake_evt_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_addr_i    (cfg_addr_i),
    .cfg_be_lo     (cfg_be_i[1:0]),
    .wr_pst        (cfg_wdata_i[1:0]),
    .pwr_state_o   (pwr_state_o),
    .pme_req_o     (pme_req_o),
    .soft_rst_o    (soft_rst_o),
    .pme_sts       (pme_sts_w),
    .pme_en        (pme_en_w),
    .data_sel      (data_sel_w)
);

// File: tb/pmcap_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for pmcap_top with default parameters (function 0, normal).
module pmcap_top_tb_top;

    localparam int NUM_DATA = 9;
    localparam logic [5:0] A_HDR = 6'h10;
    localparam logic [5:0] A_CSR = 6'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cold_exit_i = 1'b0;
    logic        aux_pwr_i = 1'b0;
    logic        pm_en_strap_i = 1'b0;
    logic        wake_evt_i = 1'b0;
    logic [NUM_DATA*8-1:0] pwr_data_i;
    logic        cfg_wr_i = 1'b0;
    logic [5:0]  cfg_addr_i = 6'h00;
    logic [3:0]  cfg_be_i = 4'h0;
    logic [31:0] cfg_wdata_i = 32'h0;
    logic [31:0] cfg_rdata_o;
    logic [1:0]  pwr_state_o;
    logic        pme_req_o;
    logic        soft_rst_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmcap_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cold_exit_i   (cold_exit_i),
        .aux_pwr_i     (aux_pwr_i),
        .pm_en_strap_i (pm_en_strap_i),
        .wake_evt_i    (wake_evt_i),
        .pwr_data_i    (pwr_data_i),
        .cfg_wr_i      (cfg_wr_i),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_be_i      (cfg_be_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_rdata_o   (cfg_rdata_o),
        .pwr_state_o   (pwr_state_o),
        .pme_req_o     (pme_req_o),
        .soft_rst_o    (soft_rst_o)
    );

    function automatic bit exp_scaled(input int s);
        return (s == 0) || (s == 3) || (s == 4) || (s == 7) || (s == 8);
    endfunction

    function automatic logic [31:0] exp_csr(input bit sts, input bit en,
                                            input int s, input logic [1:0] st);
        logic [7:0] d;
        logic [1:0] sc;
        d  = exp_scaled(s) ? 8'(8'h10 + s) : 8'h00;
        sc = exp_scaled(s) ? 2'b01 : 2'b00;
        return {d, 8'h00, sts, sc, 4'(s), en, 6'b000000, st};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_addr_i = a;
        #1;
        d = cfg_rdata_o;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d; cfg_be_i = be;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_be_i = 4'h0;
    endtask

    task automatic wake_pulse();
        @(negedge clk); wake_evt_i = 1'b1;
        @(negedge clk); wake_evt_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_HDR, d); chk("R1 R2 header after reset", d, 32'h4823_5001);
        rd(A_CSR, d); chk("R10 control after reset", d, exp_csr(0, 0, 0, 2'b00));
        chk("R10 outputs after reset", {29'd0, pwr_state_o, pme_req_o, soft_rst_o}, 32'd0);
    endtask

    task automatic t_header();
        logic [31:0] d;
        @(negedge clk); aux_pwr_i = 1'b1;
        rd(A_HDR, d); chk("R2 header with aux", d, 32'hC823_5001);
        @(negedge clk); aux_pwr_i = 1'b0;
        rd(A_HDR, d); chk("R2 header without aux", d, 32'h4823_5001);
        rd(6'h12, d); chk("R11 read above window", d, 32'h0);
        rd(6'h0F, d); chk("R11 read below window", d, 32'h0);
    endtask

    task automatic t_state();
        logic [31:0] d;
        wr(A_CSR, 32'h1, 4'h1);
        chk("R3 D1 write ignored", {30'd0, pwr_state_o}, 32'd0);
        wr(A_CSR, 32'h3, 4'h1);
        chk("R3 D3 write taken", {30'd0, pwr_state_o}, 32'd3);
        rd(A_CSR, d); chk("R3 D3 readback", d, exp_csr(0, 0, 0, 2'b11));
        chk("R4 no pulse entering D3", {31'd0, soft_rst_o}, 32'd0);
        wr(A_CSR, 32'h2, 4'h1);
        chk("R3 D2 write ignored", {30'd0, pwr_state_o}, 32'd3);
        wr(A_CSR, 32'h1, 4'h1);
        chk("R3 D1 write ignored in D3", {30'd0, pwr_state_o}, 32'd3);
        wr(A_CSR, 32'h3, 4'h1);
        chk("R4 no pulse D3 to D3", {31'd0, soft_rst_o}, 32'd0);
    endtask

    task automatic t_softrst();
        wr(A_CSR, 32'h0, 4'h1);
        chk("R4 pulse after D3 to D0", {30'd0, pwr_state_o, soft_rst_o}, 32'b001);
        @(negedge clk);
        chk("R4 pulse lasts one cycle", {31'd0, soft_rst_o}, 32'd0);
        wr(A_CSR, 32'h0, 4'h1);
        chk("R4 no pulse D0 to D0", {31'd0, soft_rst_o}, 32'd0);
        wr(A_CSR, 32'h3, 4'h2);
        chk("R11 lane 0 disabled", {30'd0, pwr_state_o}, 32'd0);
        wr(6'h12, 32'h3, 4'hF);
        chk("R11 write outside window", {30'd0, pwr_state_o}, 32'd0);
    endtask

    task automatic t_pme();
        logic [31:0] d;
        wake_pulse();
        rd(A_CSR, d); chk("R5 wake sets status without enable", d, exp_csr(1, 0, 0, 2'b00));
        chk("R6 no request without enable", {31'd0, pme_req_o}, 32'd0);
        wr(A_CSR, 32'h0000_0100, 4'h2);
        chk("R6 request with both set", {31'd0, pme_req_o}, 32'd1);
        wr(A_CSR, 32'h0000_8100, 4'h2);
        rd(A_CSR, d); chk("R5 write-one clears status", d, exp_csr(0, 1, 0, 2'b00));
        chk("R6 request drops with status", {31'd0, pme_req_o}, 32'd0);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = A_CSR; cfg_wdata_i = 32'h0000_8100; cfg_be_i = 4'h2;
        wake_evt_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_be_i = 4'h0; wake_evt_i = 1'b0;
        rd(A_CSR, d); chk("R5 wake beats same-cycle clear", d, exp_csr(1, 1, 0, 2'b00));
        wr(A_CSR, 32'h0000_8000, 4'h2);
        rd(A_CSR, d); chk("R6 enable cleared by write", d, exp_csr(0, 0, 0, 2'b00));
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(A_CSR, 32'h0000_0600, 4'h2);
        rd(A_CSR, d); chk("R7 selector held without strap", d, exp_csr(0, 0, 0, 2'b00));
        @(negedge clk); pm_en_strap_i = 1'b1;
        for (int s = 0; s < 16; s++) begin
            wr(A_CSR, 32'(s) << 9, 4'h2);
            rd(A_CSR, d); chk($sformatf("R8 selector %0d", s), d, exp_csr(0, 0, s, 2'b00));
        end
        wr(A_CSR, 32'h0000_0800, 4'h2);
        @(negedge clk); pm_en_strap_i = 1'b0;
        @(negedge clk);
        rd(A_CSR, d); chk("R7 strap drop zeroes selector", d, exp_csr(0, 0, 0, 2'b00));
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(A_CSR, 32'hFFFF_60FC, 4'hF);
        rd(A_CSR, d); chk("R9 read-only control bits", d, exp_csr(0, 0, 0, 2'b00));
        wr(A_HDR, 32'hFFFF_FFFF, 4'hF);
        rd(A_HDR, d); chk("R9 header not writable", d, 32'h4823_5001);
    endtask

    task automatic t_cold();
        logic [31:0] d;
        @(negedge clk); pm_en_strap_i = 1'b1;
        wr(A_CSR, 32'h0000_0903, 4'h3);
        wake_pulse();
        @(negedge clk); aux_pwr_i = 1'b1; cold_exit_i = 1'b1;
        cfg_wr_i = 1'b1; cfg_addr_i = A_CSR; cfg_wdata_i = 32'h0000_8000; cfg_be_i = 4'h3;
        @(negedge clk); cold_exit_i = 1'b0; cfg_wr_i = 1'b0; cfg_be_i = 4'h0;
        rd(A_CSR, d); chk("R10 cold exit with aux keeps PME", d, exp_csr(1, 1, 0, 2'b00));
        chk("R10 cold exit gives no pulse", {30'd0, pme_req_o, soft_rst_o}, 32'b10);
        @(negedge clk); aux_pwr_i = 1'b0; cold_exit_i = 1'b1;
        @(negedge clk); cold_exit_i = 1'b0;
        rd(A_CSR, d); chk("R10 cold exit without aux clears PME", d, exp_csr(0, 0, 0, 2'b00));
        wr(A_CSR, 32'h0000_0103, 4'h3);
        wake_pulse();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_CSR, d); chk("R10 full reset clears all", d, exp_csr(0, 0, 0, 2'b00));
        chk("R10 outputs after full reset", {29'd0, pwr_state_o, pme_req_o, soft_rst_o}, 32'd0);
        @(negedge clk); pm_en_strap_i = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < NUM_DATA; k++) pwr_data_i[k*8 +: 8] = 8'(8'h10 + k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_header();
        t_state();
        t_softrst();
        t_pme();
        t_select();
        t_reserved();
        t_cold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule